// File: doc/BRIEF.md
# Dual-Clock Frequency Window Monitor

This block supervises one clock against another. A sampling clock defines back-to-back measurement windows of sixteen rising edges each. During each window the block counts the rising edges of a second, monitored clock. At the end of the window it compares that count with a programmed pair of limits. A count outside the inclusive range latches an error output. A separate fault-collection unit consumes that output.

Software sets the low and high limits first and then writes the enable bit. The enable write checks that the limits are usable. If they are, monitoring starts and the limits freeze until reset. If they are not, a sticky configuration-error flag is set and the channel stays idle. The edge counter lives in the monitored clock domain. Window boundaries travel to it as a synchronized toggle. The captured count comes back as a held value, and a returning toggle announces it.

Top module: `clkmon_channel`

## Requirements
- R1: While enabled, each window spans 16 rising edges of the sampling clock, and the count taken over it equals the number of monitored-clock rising edges in that span. With a monitored clock at twice the sampling frequency the count is 32, so limits of 30 and 34 never raise `freq_err`.
- R2: A count below `lo_q` sets `freq_err`. A count equal to `lo_q` does not.
- R3: A count above `hi_q` sets `freq_err`. A count equal to `hi_q` does not.
- R4: Once `freq_err` is 1 it stays 1 until reset, and reset clears it to 0.
- R5: A write with `ctl_we`=1 and `ctl_wdata`=1 while idle starts monitoring when the stored limits satisfy low > 0 and high >= low + 3. In that case `enabled` reads 1 after the next sampling-clock edge.
- R6: An enable write with stored limits that break that rule leaves `enabled` at 0 and sets `cfg_err`, which stays 1 until reset. Low = 0 and high = low + 2 both count as breaking it.
- R7: While enabled, and in the same cycle as an enable write, limit writes leave `lo_q` and `hi_q` unchanged. Writing `ctl_wdata`=0 never clears `enabled`.
- R8: The first window result after enable is discarded. An out-of-range clock raises `freq_err` only on the second result.
- R9: After reset, `enabled`, `cfg_err`, `freq_err`, `lo_q` and `hi_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sampling clock; also clocks the register interface |
| smp_rst | input | 1 | Synchronous active-high reset, sampling domain |
| mon_clk | input | 1 | Monitored clock |
| mon_rst | input | 1 | Synchronous active-high reset, monitored domain |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 1 | Control write value; 1 requests enable |
| lo_we | input | 1 | Low-limit write strobe |
| lo_wdata | input | LIM_W | Low-limit write value |
| hi_we | input | 1 | High-limit write strobe |
| hi_wdata | input | LIM_W | High-limit write value |
| lo_q | output | LIM_W | Stored low limit |
| hi_q | output | LIM_W | Stored high limit |
| enabled | output | 1 | Monitoring active |
| cfg_err | output | 1 | Sticky flag for a rejected enable |
| freq_err | output | 1 | Sticky out-of-range flag for the fault collector |

## Verification
The enable write and a limit write can land on the same sampling edge, because each register has its own strobe. The bench drives both in one cycle in two cases. In the first, the stored limits are valid and the concurrent low-limit write would change them. In the second, the stored limits are invalid and the concurrent high-limit write would repair them. A behavioural model of the register state is compared on every clock. It shows that the concurrent write is dropped in both cases and that validity is judged on the old values. The frequency checks sit at cycle offsets derived from the window length and the synchronizer latency.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  parameter int unsigned WIN_EDGES_DEF = 16;
  parameter int unsigned LIM_W_DEF     = 12;
  parameter int unsigned CNT_W_DEF     = 12;
  parameter int unsigned MIN_GAP       = 3;

  typedef enum logic {RES_DISCARD = 1'b0, RES_JUDGE = 1'b1} res_mode_e;

  function automatic logic limits_ok(input logic [31:0] lo, input logic [31:0] hi);
    return (lo != 32'd0) && (hi >= lo + MIN_GAP);
  endfunction

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/clkmon_regs.sv
module clkmon_regs
  import clkmon_pkg::*;
#(
  parameter int unsigned LIM_W = LIM_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             ctl_wdata,
  input  logic             lo_we,
  input  logic [LIM_W-1:0] lo_wdata,
  input  logic             hi_we,
  input  logic [LIM_W-1:0] hi_wdata,
  output logic [LIM_W-1:0] lo_q,
  output logic [LIM_W-1:0] hi_q,
  output logic             enabled,
  output logic             cfg_err
);
  logic start_req;
  logic cfg_good;

  assign start_req = ctl_we && ctl_wdata && !enabled;
  assign cfg_good  = limits_ok(32'(lo_q), 32'(hi_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      enabled <= 1'b0;
      cfg_err <= 1'b0;
    end else if (start_req) begin
      if (cfg_good) enabled <= 1'b1;
      else          cfg_err <= 1'b1;
    end else if (!enabled) begin
      if (lo_we) lo_q <= lo_wdata;
      if (hi_we) hi_q <= hi_wdata;
    end
  end

  assert_limits_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    $past(enabled) |-> ($stable(lo_q) && $stable(hi_q)));
  assert_enable_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $past(enabled) |-> enabled);
  assert_enable_needs_gap_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(enabled) |-> (lo_q != '0) && ({1'b0, hi_q} >= {1'b0, lo_q} + (LIM_W+1)'(MIN_GAP)));
  assert_cfg_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_err) |-> cfg_err);
endmodule

// File: rtl/clkmon_edge_cnt.sv
module clkmon_edge_cnt
  import clkmon_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             mon_clk,
  input  logic             mon_rst,
  input  logic             win_tgl,
  output logic [CNT_W-1:0] cnt_hold,
  output logic             ack_tgl
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             win_s;
  logic             win_prev;
  logic             bnd_evt;
  logic             bnd_evt_d;
  logic [CNT_W-1:0] cnt;

  clkmon_sync #(.W(1)) u_win_sync (
    .clk (mon_clk),
    .rst (mon_rst),
    .d   (win_tgl),
    .q   (win_s)
  );

  assign bnd_evt = win_s ^ win_prev;

  always_ff @(posedge mon_clk) begin
    if (mon_rst) begin
      win_prev  <= 1'b0;
      bnd_evt_d <= 1'b0;
      ack_tgl   <= 1'b0;
      cnt       <= '0;
      cnt_hold  <= '0;
    end else begin
      win_prev  <= win_s;
      bnd_evt_d <= bnd_evt;
      if (bnd_evt_d) ack_tgl <= ~ack_tgl;
      if (bnd_evt) begin
        cnt_hold <= cnt;
        cnt      <= CNT_W'(1);
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_count_no_wrap_R1: assert property (@(posedge mon_clk) disable iff (mon_rst)
    !$past(bnd_evt) |-> (cnt >= $past(cnt)));
  assert_hold_steady_R1: assert property (@(posedge mon_clk) disable iff (mon_rst)
    !$past(bnd_evt) |-> $stable(cnt_hold));
endmodule

// File: rtl/clkmon_window.sv
module clkmon_window
  import clkmon_pkg::*;
#(
  parameter int unsigned WIN_EDGES = WIN_EDGES_DEF,
  parameter int unsigned LIM_W     = LIM_W_DEF,
  parameter int unsigned CNT_W     = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enabled,
  input  logic             ack_tgl,
  input  logic [CNT_W-1:0] cnt_hold,
  input  logic [LIM_W-1:0] lo_lim,
  input  logic [LIM_W-1:0] hi_lim,
  output logic             win_tgl,
  output logic             freq_err
);
  localparam int unsigned PH_W  = (WIN_EDGES > 1) ? $clog2(WIN_EDGES) : 1;
  localparam int unsigned CMP_W = (CNT_W > LIM_W) ? CNT_W : LIM_W;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WIN_EDGES - 1);

  logic [PH_W-1:0]  phase;
  logic             ack_s;
  logic             ack_prev;
  logic             res_evt;
  res_mode_e        mode;
  logic [CMP_W-1:0] cnt_x, lo_x, hi_x;
  logic             out_of_range;

  clkmon_sync #(.W(1)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_tgl),
    .q   (ack_s)
  );

  assign res_evt      = ack_s ^ ack_prev;
  assign cnt_x        = CMP_W'(cnt_hold);
  assign lo_x         = CMP_W'(lo_lim);
  assign hi_x         = CMP_W'(hi_lim);
  assign out_of_range = (cnt_x < lo_x) || (cnt_x > hi_x);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      win_tgl  <= 1'b0;
      ack_prev <= 1'b0;
      mode     <= RES_DISCARD;
      freq_err <= 1'b0;
    end else begin
      ack_prev <= ack_s;
      if (enabled) begin
        if (phase == PH_LAST) begin
          phase   <= '0;
          win_tgl <= ~win_tgl;
        end else begin
          phase <= phase + 1'b1;
        end
      end
      if (res_evt) begin
        if (mode == RES_DISCARD) mode <= RES_JUDGE;
        else if (out_of_range)   freq_err <= 1'b1;
      end
    end
  end

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    $past(freq_err) |-> freq_err);
  assert_first_result_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(freq_err) |-> $past(mode == RES_JUDGE));
  assert_window_needs_enable_R1: assert property (@(posedge clk) disable iff (rst)
    (win_tgl != $past(win_tgl)) |-> $past(enabled));
endmodule

// File: rtl/clkmon_channel.sv
module clkmon_channel
  import clkmon_pkg::*;
#(
  parameter int unsigned WIN_EDGES = WIN_EDGES_DEF,
  parameter int unsigned LIM_W     = LIM_W_DEF,
  parameter int unsigned CNT_W     = CNT_W_DEF
) (
  input  logic             smp_clk,
  input  logic             smp_rst,
  input  logic             mon_clk,
  input  logic             mon_rst,
  input  logic             ctl_we,
  input  logic             ctl_wdata,
  input  logic             lo_we,
  input  logic [LIM_W-1:0] lo_wdata,
  input  logic             hi_we,
  input  logic [LIM_W-1:0] hi_wdata,
  output logic [LIM_W-1:0] lo_q,
  output logic [LIM_W-1:0] hi_q,
  output logic             enabled,
  output logic             cfg_err,
  output logic             freq_err
);
  logic             win_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] cnt_hold;

  clkmon_regs #(.LIM_W(LIM_W)) u_regs (
    .clk       (smp_clk),
    .rst       (smp_rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .lo_we     (lo_we),
    .lo_wdata  (lo_wdata),
    .hi_we     (hi_we),
    .hi_wdata  (hi_wdata),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .enabled   (enabled),
    .cfg_err   (cfg_err)
  );

  clkmon_window #(.WIN_EDGES(WIN_EDGES), .LIM_W(LIM_W), .CNT_W(CNT_W)) u_window (
    .clk      (smp_clk),
    .rst      (smp_rst),
    .enabled  (enabled),
    .ack_tgl  (ack_tgl),
    .cnt_hold (cnt_hold),
    .lo_lim   (lo_q),
    .hi_lim   (hi_q),
    .win_tgl  (win_tgl),
    .freq_err (freq_err)
  );

  clkmon_edge_cnt #(.CNT_W(CNT_W)) u_edge_cnt (
    .mon_clk  (mon_clk),
    .mon_rst  (mon_rst),
    .win_tgl  (win_tgl),
    .cnt_hold (cnt_hold),
    .ack_tgl  (ack_tgl)
  );

  assert_idle_no_error_R5: assert property (@(posedge smp_clk) disable iff (smp_rst)
    !enabled |-> !freq_err);
endmodule

// File: tb/tb_clkmon_channel.sv
`timescale 1ns/1ps
module tb_clkmon_channel;
  localparam int LIM_W = 12;

  logic             smp_clk = 1'b0;
  logic             mon_clk = 1'b0;
  logic             smp_rst = 1'b1;
  logic             mon_rst = 1'b1;
  logic             ctl_we = 1'b0, ctl_wdata = 1'b0;
  logic             lo_we = 1'b0, hi_we = 1'b0;
  logic [LIM_W-1:0] lo_wdata = '0, hi_wdata = '0;
  logic [LIM_W-1:0] lo_q, hi_q;
  logic             enabled, cfg_err, freq_err;

  real mon_half = 2.0;
  int  n_chk = 0, n_fail = 0;
  bit  done = 0, model_on = 0;

  int m_lo, m_hi;
  bit m_en, m_cfg;

  clkmon_channel dut (
    .smp_clk(smp_clk), .smp_rst(smp_rst), .mon_clk(mon_clk), .mon_rst(mon_rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_q(lo_q), .hi_q(hi_q),
    .enabled(enabled), .cfg_err(cfg_err), .freq_err(freq_err)
  );

  always #4 smp_clk = ~smp_clk;
  initial begin
    #1;
    forever #(mon_half) mon_clk = ~mon_clk;
  end

  task automatic chk(input int got, input int exp, input string req, input string what);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // Per-cycle comparison of the register state with the behavioural model.
  always @(negedge smp_clk) begin
    if (model_on && !smp_rst) begin
      chk(int'(lo_q), m_lo, "R7", "lo_q vs model");
      chk(int'(hi_q), m_hi, "R7", "hi_q vs model");
      chk(int'(enabled), int'(m_en), "R5", "enabled vs model");
      chk(int'(cfg_err), int'(m_cfg), "R6", "cfg_err vs model");
    end
  end

  task automatic do_reset(input real half);
    @(negedge smp_clk);
    model_on = 0;
    smp_rst = 1'b1;
    mon_rst = 1'b1;
    mon_half = half;
    repeat (6) @(negedge smp_clk);
    smp_rst = 1'b0;
    mon_rst = 1'b0;
    m_lo = 0; m_hi = 0; m_en = 0; m_cfg = 0;
    model_on = 1;
    chk(int'(freq_err), 0, "R9", "freq_err after reset");
    chk(int'(enabled) + int'(cfg_err) + int'(lo_q) + int'(hi_q), 0, "R9", "register state after reset");
  endtask

  task automatic wr(input bit c_we, input bit c_d, input bit l_we, input int l_d,
                    input bit h_we, input int h_d);
    bit start;
    ctl_we = c_we; ctl_wdata = c_d;
    lo_we = l_we; lo_wdata = LIM_W'(l_d);
    hi_we = h_we; hi_wdata = LIM_W'(h_d);
    @(posedge smp_clk);
    start = c_we && c_d && !m_en;
    if (start) begin
      if (m_lo > 0 && m_hi >= m_lo + 3) m_en = 1;
      else m_cfg = 1;
    end else if (!m_en) begin
      if (l_we) m_lo = l_d;
      if (h_we) m_hi = h_d;
    end
    @(negedge smp_clk);
    ctl_we = 0; ctl_wdata = 0; lo_we = 0; hi_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge smp_clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Monitored clock at 250 MHz: 32 edges per window.
    do_reset(2.0);
    wr(0, 0, 1, 0, 1, 10);
    wr(1, 1, 0, 0, 0, 0);                 // R6: low limit zero rejected
    chk(int'(cfg_err), 1, "R6", "cfg_err after low=0 enable");
    wr(0, 0, 1, 5, 1, 7);
    wr(1, 1, 0, 0, 0, 0);                 // R6: gap of two rejected
    chk(int'(enabled), 0, "R6", "enabled with high=low+2");
    wr(0, 0, 0, 0, 1, 8);
    wr(1, 1, 0, 0, 0, 0);                 // R5: gap of three accepted
    chk(int'(enabled), 1, "R5", "enabled with high=low+3");
    repeat (28) @(negedge smp_clk);
    chk(int'(freq_err), 0, "R8", "first result discarded");
    repeat (22) @(negedge smp_clk);
    chk(int'(freq_err), 1, "R3", "count 32 above high 8");
    wr(0, 0, 1, 1, 1, 4000);              // R7: ignored while enabled
    wr(1, 0, 0, 0, 0, 0);                 // R7: enable cannot be cleared
    chk(int'(lo_q), 5, "R7", "lo_q locked");
    repeat (200) @(negedge smp_clk);
    chk(int'(freq_err), 1, "R4", "freq_err sticky");

    // Same-cycle enable and limit write with valid stored limits.
    do_reset(2.0);
    chk(int'(freq_err), 0, "R4", "reset clears freq_err");
    wr(0, 0, 1, 30, 1, 34);
    wr(1, 1, 1, 100, 0, 0);
    chk(int'(lo_q), 30, "R7", "concurrent low write dropped");
    repeat (400) @(negedge smp_clk);
    chk(int'(freq_err), 0, "R1", "count 32 inside 30..34");

    // Monitored clock at 62.5 MHz: 8 edges per window.
    do_reset(8.0);
    wr(0, 0, 1, 8, 1, 9);
    wr(1, 1, 0, 0, 1, 11);                // old limits judged, write dropped
    chk(int'(cfg_err), 1, "R6", "invalid stored limits despite concurrent fix");
    chk(int'(hi_q), 9, "R7", "concurrent high write dropped");
    wr(0, 0, 0, 0, 1, 11);
    wr(1, 1, 0, 0, 0, 0);
    chk(int'(enabled), 1, "R5", "enable after repair");
    repeat (300) @(negedge smp_clk);
    chk(int'(freq_err), 0, "R2", "count equal to low");

    do_reset(8.0);
    wr(0, 0, 1, 5, 1, 8);
    wr(1, 1, 0, 0, 0, 0);
    repeat (300) @(negedge smp_clk);
    chk(int'(freq_err), 0, "R3", "count equal to high");

    do_reset(8.0);
    wr(0, 0, 1, 9, 1, 12);
    wr(1, 1, 0, 0, 0, 0);
    repeat (100) @(negedge smp_clk);
    chk(int'(freq_err), 1, "R2", "count 8 below low 9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule